// File: doc/BRIEF.md
# Late-Write Pipelined Synchronous SRAM

This block models a synchronous single-port memory whose data phase trails its command phase by a fixed two cycles, for reads and writes alike. On each rising clock edge it takes an address, a read/write select, a load-or-advance select, per-lane write enables and three chip enables. Because a write's data arrives on the same cycle offset as a read's data, reads and writes can be issued in any mix, one per cycle, and the data bus never needs an idle cycle to change direction.

A load cycle starts a four-beat burst at the given address. Advance cycles step through the remaining beats in linear or interleaved order, and they reuse the direction and chip-select outcome of the load. The data bus is modelled as a separate input and output plus an output-enable flag. The block raises that flag from its own pipeline state during read data cycles, so no outside enable sequencing is needed. A read that targets a word whose write is still in flight gets the pending bytes merged over the stored ones.

The command side has no flow control. The block is always ready and takes one command per clock, valid or deselected, so no back-pressure exists. Write data has no valid signal of its own: it is taken exactly two cycles after its command.

Top module: `late_write_sram`

## Requirements
- R1: While `rst_n` is low and after its release, `rdata_oe` is 0 and `rdata` is all zeros. No burst is active, so an advance cycle that comes before any load is a deselect.
- R2: A selected read command sampled at rising edge E appears on `rdata`, with `rdata_oe` high, in the cycle between the next edge and the one after it. That is the second cycle after the command's own cycle.
- R3: For a selected write command sampled at edge E, `wdata` is sampled at the second edge after E. `wdata` is ignored on every other edge.
- R4: Reads and writes issued on consecutive cycles in any order each complete, with no idle cycle between them.
- R5: A load cycle is selected only when `cs_a_n`=0, `cs_b`=1 and `cs_c_n`=0. Any other combination deselects it: nothing is written, and `rdata_oe` is low two cycles later.
- R6: `cmd_adv`=0 loads a burst at `cmd_addr` as beat 0, and each `cmd_adv`=1 cycle moves to the next beat k. With `order_sel`=0 (linear), the two low address bits are (start+k) mod 4. With `order_sel`=1 (interleaved), they are start XOR k. The upper address bits stay those of the start. After beat 3 the beat count wraps to 0.
- R7: On advance cycles, `cmd_we`, `cmd_addr` and the chip enables are ignored: the beat takes the direction and selection of its load. Advance cycles after a deselected load are deselects.
- R8: A word is four 9-bit lanes, and lane i is `wdata`/`rdata` bits [9i+8:9i]. `lane_wen[i]`=1, sampled with the command, writes lane i. A lane whose enable is 0 keeps its stored value.
- R9: A read issued in the cycle right after a write to the same address returns the write's enabled lanes from `wdata`, merged over the previously stored lanes.
- R10: `rdata_oe` is high only in read data cycles. In every other cycle `rdata` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_addr | input | ADDR_W | Word address for load cycles |
| cmd_we | input | 1 | 1 = write, 0 = read (load cycles only) |
| cmd_adv | input | 1 | 1 = advance burst, 0 = load new address |
| cs_a_n | input | 1 | Chip enable, active low |
| cs_b | input | 1 | Chip enable, active high |
| cs_c_n | input | 1 | Chip enable, active low |
| lane_wen | input | LANES | Per-lane write enables, taken with the command |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved |
| wdata | input | LANES*LANE_W | Write data, two cycles after its command |
| rdata | output | LANES*LANE_W | Read data, zero when not driven |
| rdata_oe | output | 1 | High in read data cycles |

## Verification
Two events can land on the same edge: a pending write commits to the array while a later read samples the array at that same address. The bench sets this up by issuing a read straight after a write to one word, with full and with partial lane enables. It also starts a read burst right behind a write burst over the same four words. A sequential shadow memory that applies every write at its issue time gives the expected merged word. A mismatch on any lane, or on the enable flag, is reported against R9.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;

  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } beat_order_e;

  // Low two address bits of beat k in a burst starting at 'start'.
  function automatic logic [1:0] beat_lo(input logic [1:0] start,
                                         input logic [1:0] beat,
                                         input beat_order_e ord);
    return (ord == ORD_XOR) ? (start ^ beat) : (start + beat);
  endfunction

endpackage

// File: rtl/lw_burst_seq.sv
module lw_burst_seq
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_we,
  input  logic              cmd_adv,
  input  logic              sel_ok,
  input  beat_order_e       order,
  output logic              iss_valid,
  output logic              iss_wr,
  output logic [ADDR_W-1:0] iss_addr
);

  logic              live_q;
  logic              wr_q;
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        beat_q;
  logic [1:0]        beat_nx;

  assign beat_nx = beat_q + 2'd1;

  // Load cycles pass the command through; advance cycles replay the burst.
  always_comb begin
    if (!cmd_adv) begin
      iss_valid = sel_ok;
      iss_wr    = cmd_we;
      iss_addr  = cmd_addr;
    end else begin
      iss_valid = live_q;
      iss_wr    = wr_q;
      iss_addr  = {base_q[ADDR_W-1:2], beat_lo(base_q[1:0], beat_nx, order)};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      wr_q   <= 1'b0;
      base_q <= '0;
      beat_q <= 2'd0;
    end else if (!cmd_adv) begin
      live_q <= sel_ok;
      wr_q   <= cmd_we;
      base_q <= cmd_addr;
      beat_q <= 2'd0;
    end else if (live_q) begin
      beat_q <= beat_nx;
    end
  end

  // R6: linear bursts step the low bits by one each beat
  p_linear_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_adv && live_q && order == ORD_LINEAR && $stable(order))
      |-> iss_addr[1:0] == $past(iss_addr[1:0]) + 2'd1);

  // R6: interleaved bursts step the XOR distance from the start by one
  p_xor_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_adv && live_q && order == ORD_XOR && $stable(order))
      |-> (iss_addr[1:0] ^ base_q[1:0]) == (($past(iss_addr[1:0]) ^ base_q[1:0]) + 2'd1));

  // R7: advance cycles keep the upper address bits of the burst start
  p_adv_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_adv && live_q) |-> iss_addr[ADDR_W-1:2] == $past(iss_addr[ADDR_W-1:2]));

endmodule

// File: rtl/lw_cmd_pipe.sv
module lw_cmd_pipe #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_wr,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [LANES-1:0]  in_lanes,
  output logic              s1_valid,
  output logic              s1_wr,
  output logic [ADDR_W-1:0] s1_addr,
  output logic              s2_valid,
  output logic              s2_wr,
  output logic [ADDR_W-1:0] s2_addr,
  output logic [LANES-1:0]  s2_lanes
);

  // Data phase trails the command by this many edges.
  localparam int STAGES = 2;

  typedef struct packed {
    logic              v;
    logic              w;
    logic [ADDR_W-1:0] a;
    logic [LANES-1:0]  l;
  } stage_t;

  stage_t st_in;
  stage_t st_q [STAGES];

  assign st_in = '{v: in_valid, w: in_wr, a: in_addr, l: in_lanes};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st_q[i] <= '0;
    end else begin
      st_q[0] <= st_in;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign s1_valid = st_q[0].v;
  assign s1_wr    = st_q[0].w;
  assign s1_addr  = st_q[0].a;
  assign s2_valid = st_q[STAGES-1].v;
  assign s2_wr    = st_q[STAGES-1].w;
  assign s2_addr  = st_q[STAGES-1].a;
  assign s2_lanes = st_q[STAGES-1].l;

  // R5: a deselected command never reaches the commit stage as valid
  p_desel_flows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ##1 !s2_valid);

endmodule

// File: rtl/lw_store.sv
module lw_store #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rd_valid,
  input  logic [ADDR_W-1:0]       rd_addr,
  input  logic                    wr_valid,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES-1:0]        wr_lanes,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdata_oe
);

  localparam int WORD_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] wmask;
  logic [WORD_W-1:0] wr_word;
  logic [WORD_W-1:0] rd_word;
  logic              same_word;

  assign same_word = wr_valid && (wr_addr == rd_addr);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign wmask[g*LANE_W +: LANE_W] = {LANE_W{wr_lanes[g]}};
    // Forward the committing write's lane over the stored lane.
    assign rd_word[g*LANE_W +: LANE_W] = (same_word && wr_lanes[g])
                                       ? wdata[g*LANE_W +: LANE_W]
                                       : mem[rd_addr][g*LANE_W +: LANE_W];
  end

  assign wr_word = (mem[wr_addr] & ~wmask) | (wdata & wmask);

  always_ff @(posedge clk) begin
    if (wr_valid) mem[wr_addr] <= wr_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_oe <= 1'b0;
      rdata    <= '0;
    end else begin
      rdata_oe <= rd_valid;
      rdata    <= rd_valid ? rd_word : '0;
    end
  end

  // R9: a read colliding with a committing write sees the new lanes
  p_bypass_lanes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && same_word) |=> ((rdata & $past(wmask)) == $past(wdata & wmask)));

  // R10: the bus is quiet whenever the enable flag is low
  p_quiet_bus_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> (!rdata_oe && rdata == '0));

endmodule

// File: rtl/late_write_sram.sv
module late_write_sram
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_we,
  input  logic              cmd_adv,
  input  logic              cs_a_n,
  input  logic              cs_b,
  input  logic              cs_c_n,
  input  logic [LANES-1:0]  lane_wen,
  input  logic              order_sel,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic              rdata_oe
);

  logic              sel_ok;
  logic              iss_valid, iss_wr;
  logic [ADDR_W-1:0] iss_addr;
  logic              s1_valid, s1_wr, s2_valid, s2_wr;
  logic [ADDR_W-1:0] s1_addr, s2_addr;
  logic [LANES-1:0]  s2_lanes;

  assign sel_ok = !cs_a_n && cs_b && !cs_c_n;

  lw_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_addr (cmd_addr),
    .cmd_we   (cmd_we),
    .cmd_adv  (cmd_adv),
    .sel_ok   (sel_ok),
    .order    (beat_order_e'(order_sel)),
    .iss_valid(iss_valid),
    .iss_wr   (iss_wr),
    .iss_addr (iss_addr)
  );

  lw_cmd_pipe #(.ADDR_W(ADDR_W), .LANES(LANES)) u_pipe (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(iss_valid),
    .in_wr   (iss_wr),
    .in_addr (iss_addr),
    .in_lanes(lane_wen),
    .s1_valid(s1_valid),
    .s1_wr   (s1_wr),
    .s1_addr (s1_addr),
    .s2_valid(s2_valid),
    .s2_wr   (s2_wr),
    .s2_addr (s2_addr),
    .s2_lanes(s2_lanes)
  );

  lw_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_valid(s1_valid && !s1_wr),
    .rd_addr (s1_addr),
    .wr_valid(s2_valid && s2_wr),
    .wr_addr (s2_addr),
    .wr_lanes(s2_lanes),
    .wdata   (wdata),
    .rdata   (rdata),
    .rdata_oe(rdata_oe)
  );

  // R2: a selected read drives the bus in its second cycle after capture
  p_read_oe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_wr) |=> ##1 rdata_oe);

  // R10: the enable flag follows only a read in the first stage
  p_oe_only_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_oe |-> $past(s1_valid && !s1_wr));

  // R5: a deselected load leaves the bus undriven two cycles on
  p_desel_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_adv && !sel_ok) |=> ##1 !rdata_oe);

  // R3: a write never drives the bus in its data cycle
  p_write_no_oe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_wr) |=> ##1 !rdata_oe);

endmodule

// File: tb/test_late_write_sram.sv
module test_late_write_sram;
  localparam int AW = 8;
  localparam int LN = 4;
  localparam int LW = 9;
  localparam int WW = LN * LW;
  localparam logic [2:0]    SEL  = 3'b010;  // {cs_a_n, cs_b, cs_c_n}
  localparam logic [2:0]    OFFA = 3'b110;
  localparam logic [WW-1:0] JUNK = 36'h5A5A5A5A5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic [AW-1:0] cmd_addr;
  logic          cmd_we, cmd_adv, cs_a_n, cs_b, cs_c_n, order_sel;
  logic [LN-1:0] lane_wen;
  logic [WW-1:0] wdata, rdata;
  logic          rdata_oe;

  late_write_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) i_late_write_sram (
    .clk(clk), .rst_n(rst_n), .cmd_addr(cmd_addr), .cmd_we(cmd_we),
    .cmd_adv(cmd_adv), .cs_a_n(cs_a_n), .cs_b(cs_b), .cs_c_n(cs_c_n),
    .lane_wen(lane_wen), .order_sel(order_sel), .wdata(wdata),
    .rdata(rdata), .rdata_oe(rdata_oe)
  );

  typedef struct {
    int            due;
    logic          oe;
    logic [WW-1:0] data;
    string         tag;
  } exp_t;

  exp_t          q[$];
  int            cyc = 0;
  int            n_run = 0;
  int            n_fail = 0;
  logic [WW-1:0] shadow [1 << AW];
  logic          m_live, m_wr;
  logic [AW-1:0] m_base;
  logic [1:0]    m_beat;
  logic          ord_cfg;
  logic [WW-1:0] wbuf [4];
  logic          wpend [4];

  function automatic logic [1:0] exp_lo(input logic [1:0] s, input logic [1:0] k,
                                        input logic ilv);
    logic [1:0] r;
    if (ilv) r = s ^ k;
    else     r = s + k;
    return r;
  endfunction

  // Monitor: pops every entry due at this edge and compares.
  always @(posedge clk) begin
    exp_t e;
    cyc++;
    #1;
    while (q.size() > 0 && q[0].due == cyc) begin
      e = q.pop_front();
      n_run++;
      if (rdata_oe !== e.oe || rdata !== (e.oe ? e.data : '0)) begin
        n_fail++;
        $display("FAIL %s: oe=%b data=%h expected oe=%b data=%h",
                 e.tag, rdata_oe, rdata, e.oe, e.oe ? e.data : '0);
      end
    end
  end

  // Driver: one command per cycle; pushes the expected bus state.
  task automatic step(input logic adv, input logic we, input logic [2:0] cs,
                      input logic [AW-1:0] a, input logic [LN-1:0] ln,
                      input logic [WW-1:0] d, input string tag);
    logic          v, w;
    logic [AW-1:0] ea;
    exp_t          e;
    @(negedge clk);
    cmd_adv   = adv;
    cmd_we    = we;
    {cs_a_n, cs_b, cs_c_n} = cs;
    cmd_addr  = a;
    lane_wen  = ln;
    order_sel = ord_cfg;
    if (wpend[cyc % 4]) begin
      wdata = wbuf[cyc % 4];
      wpend[cyc % 4] = 1'b0;
    end else begin
      wdata = JUNK;
    end
    if (!adv) begin
      v = (cs == SEL);
      w = we;
      m_live = v; m_wr = we; m_base = a; m_beat = 2'd0;
      ea = a;
    end else begin
      v = m_live;
      w = m_wr;
      if (m_live) m_beat = m_beat + 2'd1;
      ea = {m_base[AW-1:2], exp_lo(m_base[1:0], m_beat, ord_cfg)};
    end
    e.due  = cyc + 2;
    e.tag  = tag;
    e.oe   = v && !w;
    e.data = '0;
    if (v && !w) e.data = shadow[ea];
    if (v && w) begin
      for (int i = 0; i < LN; i++)
        if (ln[i]) shadow[ea][i*LW +: LW] = d[i*LW +: LW];
      wbuf[(cyc + 2) % 4]  = d;
      wpend[(cyc + 2) % 4] = 1'b1;
    end
    q.push_back(e);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_addr = '0; cmd_we = 1'b0; cmd_adv = 1'b0;
    {cs_a_n, cs_b, cs_c_n} = OFFA; lane_wen = '0; order_sel = 1'b0;
    wdata = JUNK; ord_cfg = 1'b0; m_live = 1'b0; m_wr = 1'b0;
    m_base = '0; m_beat = 2'd0;
    for (int i = 0; i < 4; i++) begin wpend[i] = 1'b0; wbuf[i] = '0; end
    repeat (3) @(negedge clk);
    n_run++;
    if (rdata_oe !== 1'b0 || rdata !== '0) begin
      n_fail++;
      $display("FAIL R1 reset: oe=%b data=%h expected oe=0 data=0", rdata_oe, rdata);
    end
    rst_n = 1'b1;

    // R1 / R7: advance before any load is a deselect
    step(1, 0, SEL, 8'h00, 4'hF, '0, "R1 advance before load");
    // R3 / R2: single writes, then reads
    step(0, 1, SEL, 8'h20, 4'hF, 36'h123456789, "R3 write 0x20");
    step(0, 1, SEL, 8'h21, 4'hF, 36'hABCDEF012, "R3 write 0x21");
    step(0, 0, SEL, 8'h20, 4'h0, '0, "R2 read 0x20");
    step(0, 0, SEL, 8'h21, 4'h0, '0, "R2 read 0x21");
    // R4 / R9 / R8: alternating directions, same-address collisions
    step(0, 1, SEL, 8'h30, 4'hF, 36'h111111111, "R4 write 0x30");
    step(0, 0, SEL, 8'h30, 4'h0, '0, "R9 read right after write");
    step(0, 1, SEL, 8'h30, 4'b0101, 36'h222222222, "R8 partial write");
    step(0, 0, SEL, 8'h30, 4'h0, '0, "R9 merged bypass read");
    step(0, 1, SEL, 8'h20, 4'b1000, 36'hFFFFFFFFF, "R8 top lane write");
    step(0, 0, SEL, 8'h21, 4'h0, '0, "R4 read after write");
    step(0, 0, SEL, 8'h20, 4'h0, '0, "R8 disabled lanes kept");
    // R5: each chip enable alone deselects
    step(0, 1, 3'b110, 8'h21, 4'hF, 36'h000000000, "R5 cs_a_n high");
    step(0, 1, 3'b000, 8'h21, 4'hF, 36'h000000000, "R5 cs_b low");
    step(0, 1, 3'b011, 8'h21, 4'hF, 36'h000000000, "R5 cs_c_n high");
    step(0, 0, 3'b011, 8'h21, 4'hF, 36'h000000000, "R5 deselected read");
    step(0, 0, SEL, 8'h21, 4'h0, '0, "R5 word unchanged");
    // R6 / R7: linear write burst from 0x42, advance ignores we/cs
    step(0, 1, SEL, 8'h42, 4'hF, 36'h0A0A0A0A0, "R6 linear load");
    step(1, 0, OFFA, 8'hFF, 4'hF, 36'h0B0B0B0B0, "R7 advance ignores we and cs");
    step(1, 1, SEL, 8'h00, 4'hF, 36'h0C0C0C0C0, "R6 linear beat 2");
    step(1, 1, SEL, 8'h00, 4'hF, 36'h0D0D0D0D0, "R6 linear beat 3");
    for (int k = 0; k < 4; k++)
      step(0, 0, SEL, 8'h40 + AW'(k), 4'h0, '0, "R6 linear burst readback");
    // R6 / R7: interleaved read burst from 0x43
    ord_cfg = 1'b1;
    step(0, 0, SEL, 8'h43, 4'h0, '0, "R6 interleaved load read");
    step(1, 1, SEL, 8'h00, 4'hF, '0, "R7 advance keeps read");
    step(1, 1, OFFA, 8'h00, 4'hF, '0, "R6 interleaved beat 2");
    step(1, 0, SEL, 8'h00, 4'h0, '0, "R6 interleaved beat 3");
    // R6 / R9: interleaved write burst at 0x55, then linear read burst with wrap
    step(0, 1, SEL, 8'h55, 4'hF, 36'h100000001, "R6 interleaved write load");
    step(1, 1, SEL, 8'h00, 4'hF, 36'h200000002, "R6 interleaved write beat");
    step(1, 1, SEL, 8'h00, 4'hF, 36'h300000003, "R6 interleaved write beat");
    step(1, 1, SEL, 8'h00, 4'hF, 36'h400000004, "R6 interleaved write beat");
    ord_cfg = 1'b0;
    step(0, 0, SEL, 8'h56, 4'h0, '0, "R9 burst read behind burst write");
    for (int k = 0; k < 4; k++)
      step(1, 0, SEL, 8'h00, 4'h0, '0, "R6 linear read beats and wrap");
    // R7: advances after a deselected load stay deselected
    step(0, 1, 3'b111, 8'h56, 4'hF, 36'h777777777, "R7 deselected load");
    step(1, 0, SEL, 8'h56, 4'hF, '0, "R7 advance after deselect");
    step(1, 1, SEL, 8'h56, 4'hF, 36'h777777777, "R7 advance after deselect");
    step(0, 0, SEL, 8'h56, 4'h0, '0, "R7 word untouched");
    // R10: idle cycles drain the pipeline
    for (int k = 0; k < 3; k++)
      step(0, 0, OFFA, 8'h00, 4'h0, '0, "R10 idle bus quiet");
    repeat (4) @(negedge clk);
    n_run++;
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL R4 scoreboard drained: left=%0d expected 0", q.size());
    end
    summary();
    $finish;
  end

endmodule